// File: doc/BRIEF.md
# Cascaded Serial DAC Update Controller

This block is a host-side master that loads new output codes into a chain of serially cascaded digital-to-analog converters. All converters share one serial clock and one combined select/load line; each device's serial output feeds the next device's serial input. The host presents one 14-bit code per device on a flat parallel bus and pulses `start`. The controller packs every code into a 16-bit frame, shifts the whole chain's bit stream out during a single select-low window, and then raises the select/load line. That one rising edge latches the new code into every converter at once. The controller then pulses `done` for one cycle.

All serial timing comes from the system clock. Parameters give the minimum device timings as whole system-clock cycle counts, rounded up. These timings are the select-fall-to-first-clock delay, the clock high and low widths, the last-clock-to-load delay and the load pulse width. The serial clock always rests low before the select line falls. Serial data changes only on falling serial-clock edges, so the device's zero hold time is met.

Top module: `dac_chain_ctrl`

## Requirements
- R1: While reset is active and whenever the block is idle, `cs_ld` is 1, `sclk` is 0, `done` is 0 and `busy` is 0.
- R2: A transfer shifts exactly `N_DEV*16` bits on rising `sclk` edges, in this order: device index `N_DEV-1` first and device 0 (nearest the controller) last. Device d's code is `codes[d*14 +: 14]`. Each 16-bit frame is that code, most significant bit first, followed by two pad bits of value 0.
- R3: `cs_ld` falls only while `sclk` is low. The first rising `sclk` edge comes exactly `SETUP_CYC` system cycles after `cs_ld` falls.
- R4: Every `sclk` high phase lasts exactly `HIGH_CYC` cycles. Every low phase between two rising edges of one transfer lasts exactly `LOW_CYC` cycles.
- R5: `sdo` holds its value for the whole of every `sclk` high phase, including the cycle in which `sclk` rises.
- R6: After the last `sclk` high phase ends, `sclk` stays low. `cs_ld` rises exactly `PRELOAD_CYC` cycles after that last falling edge.
- R7: `cs_ld` stays high for `LOAD_CYC` cycles before `done` pulses for exactly one cycle. `done` comes `SETUP_CYC + 16*N_DEV*HIGH_CYC + (16*N_DEV-1)*LOW_CYC + PRELOAD_CYC + LOAD_CYC + 1` cycles after the clock edge that samples `start`. `busy` is high from the cycle after that edge through the `done` cycle.
- R8: A `start` pulse, and any change on `codes`, while `busy` is high does not affect the bit stream. It also does not cause a second transfer after `done`.
- R9: Each transfer has exactly one `cs_ld` low window, and `sclk` is high only while `cs_ld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a transfer; taken only when idle |
| codes | input | N_DEV*14 | One 14-bit code per device; device d at bits d*14 upward |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle pulse after the load pulse ends |
| sclk | output | 1 | Serial clock to the chain |
| sdo | output | 1 | Serial data to the first device |
| cs_ld | output | 1 | Active-low select; its rising edge loads all devices |

## Verification
The bound checker enforces the ordering rules on every cycle. These rules are: `cs_ld` falls only with `sclk` low, `sclk` is high only inside the select window, `sdo` is stable across each high phase, and `done` is a single-cycle pulse that arrives with `cs_ld` high and the idle outputs quiet. The exact cycle counts of each phase, the bit order across frames with their zero padding, the end-to-end latency and the rejection of `start` during a transfer are shown only by the bench. The bench drives directed and random code sets and measures every edge of the serial waveform against values worked out from the parameters.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT_HI,
    ST_SHIFT_LO,
    ST_PRE_LOAD,
    ST_LOAD_PULSE,
    ST_DONE
  } ctrl_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_chain_rst_sync.sv
module dac_chain_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/dac_chain_timer.sv
module dac_chain_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dac_chain_shifter.sv
module dac_chain_shifter #(
  parameter int LEN = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic [LEN-1:0] par_in,
  output logic           ser_out
);
  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] sr_d;
  logic           sr_en;

  always_comb begin
    sr_en = load | shift;
    if (load) sr_d = par_in;
    else      sr_d = {sr_q[LEN-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign ser_out = sr_q[LEN-1];
endmodule

// File: rtl/dac_chain_ctrl.sv
module dac_chain_ctrl
  import dac_chain_pkg::*;
#(
  parameter int N_DEV       = 4,
  parameter int CODE_W      = 14,
  parameter int PAD_W       = 2,
  parameter int SETUP_CYC   = 12,
  parameter int HIGH_CYC    = 12,
  parameter int LOW_CYC     = 12,
  parameter int PRELOAD_CYC = 12,
  parameter int LOAD_CYC    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N_DEV*CODE_W-1:0] codes,
  output logic                    busy,
  output logic                    done,
  output logic                    sclk,
  output logic                    sdo,
  output logic                    cs_ld
);
  localparam int FRAME_W = CODE_W + PAD_W;
  localparam int TOTAL   = N_DEV * FRAME_W;
  localparam int BIT_W   = $clog2(TOTAL);
  localparam int T_MAX   = max2(max2(max2(SETUP_CYC, HIGH_CYC), max2(LOW_CYC, PRELOAD_CYC)), LOAD_CYC);
  localparam int CNT_W   = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] L_HIGH  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] L_LOW   = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] L_PRE   = CNT_W'(PRELOAD_CYC - 1);
  localparam logic [CNT_W-1:0] L_LOAD  = CNT_W'(LOAD_CYC - 1);
  localparam logic [BIT_W-1:0] L_BITS  = BIT_W'(TOTAL - 1);

  logic             srst_n;
  ctrl_state_e      state_q, state_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift;
  logic [BIT_W-1:0] bits_q, bits_d;
  logic             bits_en;
  logic [TOTAL-1:0] frame_vec;
  logic             busy_d, done_d, sclk_d, cs_d;

  dac_chain_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Device d's frame sits at slice d, so the highest index leaves first.
  for (genvar d = 0; d < N_DEV; d++) begin : g_frame
    assign frame_vec[d*FRAME_W +: FRAME_W] = {codes[d*CODE_W +: CODE_W], {PAD_W{1'b0}}};
  end

  dac_chain_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  dac_chain_shifter #(.LEN(TOTAL)) u_shift (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (sh_load),
    .shift   (sh_shift),
    .par_in  (frame_vec),
    .ser_out (sdo)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    bits_en  = 1'b0;
    bits_d   = bits_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = L_SETUP;
        sh_load  = 1'b1;
        bits_en  = 1'b1;
        bits_d   = L_BITS;
      end
      ST_SETUP: if (tmr_zero) begin
        state_d  = ST_SHIFT_HI;
        tmr_load = 1'b1;
        tmr_val  = L_HIGH;
      end
      ST_SHIFT_HI: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (bits_q == '0) begin
          state_d = ST_PRE_LOAD;
          tmr_val = L_PRE;
        end else begin
          state_d  = ST_SHIFT_LO;
          tmr_val  = L_LOW;
          sh_shift = 1'b1;
          bits_en  = 1'b1;
          bits_d   = bits_q - 1'b1;
        end
      end
      ST_SHIFT_LO: if (tmr_zero) begin
        state_d  = ST_SHIFT_HI;
        tmr_load = 1'b1;
        tmr_val  = L_HIGH;
      end
      ST_PRE_LOAD: if (tmr_zero) begin
        state_d  = ST_LOAD_PULSE;
        tmr_load = 1'b1;
        tmr_val  = L_LOAD;
      end
      ST_LOAD_PULSE: if (tmr_zero) state_d = ST_DONE;
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // Outputs are decoded from the next state and registered, so pins never glitch.
  always_comb begin
    busy_d = (state_d != ST_IDLE);
    done_d = (state_d == ST_DONE);
    sclk_d = (state_d == ST_SHIFT_HI);
    cs_d   = !((state_d == ST_SETUP) || (state_d == ST_SHIFT_HI) ||
               (state_d == ST_SHIFT_LO) || (state_d == ST_PRE_LOAD));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      cs_ld   <= 1'b1;
    end else begin
      state_q <= state_d;
      busy    <= busy_d;
      done    <= done_d;
      sclk    <= sclk_d;
      cs_ld   <= cs_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      bits_q <= '0;
    else if (bits_en) bits_q <= bits_d;
  end
endmodule

// File: rtl/dac_chain_ctrl_chk.sv
module dac_chain_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdo,
  input logic cs_ld
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_ld && !sclk && !done));

  assert_cs_fall_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_ld) |-> !sclk);

  assert_sdo_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo));

  assert_clk_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_ld);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_ld && busy && !sclk));

  assert_load_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_ld) |-> !sclk);
endmodule

bind dac_chain_ctrl dac_chain_ctrl_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .done  (done),
  .sclk  (sclk),
  .sdo   (sdo),
  .cs_ld (cs_ld)
);

// File: tb/dac_chain_ctrl_test.sv
`timescale 1ns/1ps
module dac_chain_ctrl_test;
  localparam int N_DEV = 3;
  localparam int CW    = 14;
  localparam int TOT   = N_DEV * 16;
  localparam int T_S   = 7;
  localparam int T_H   = 5;
  localparam int T_L   = 6;
  localparam int T_P   = 8;
  localparam int T_LD  = 10;
  localparam int LAT   = T_S + TOT*T_H + (TOT-1)*T_L + T_P + T_LD + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N_DEV*CW-1:0] codes = '0;
  logic busy, done, sclk, sdo, cs_ld;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dac_chain_ctrl #(.N_DEV(N_DEV), .SETUP_CYC(T_S), .HIGH_CYC(T_H), .LOW_CYC(T_L),
                   .PRELOAD_CYC(T_P), .LOAD_CYC(T_LD)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .codes(codes),
    .busy(busy), .done(done), .sclk(sclk), .sdo(sdo), .cs_ld(cs_ld));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [TOT-1:0] expect_stream(input logic [N_DEV*CW-1:0] c);
    logic [TOT-1:0] v = '0;
    for (int d = N_DEV-1; d >= 0; d--) begin
      for (int b = CW-1; b >= 0; b--) v = {v[TOT-2:0], c[d*CW+b]};
      v = {v[TOT-3:0], 2'b00};
    end
    return v;
  endfunction

  task automatic run_xfer(input logic [N_DEV*CW-1:0] c, input int poke_at);
    logic [TOT-1:0] got = '0;
    logic [TOT-1:0] exp_v;
    int cyc = 0, rises = 0, cs_falls = 0;
    int cs_fall_c = -1, first_rise_c = -1, rise_c = -1, fall_c = -1, cs_rise_c = -1, done_c = -1;
    int bad_hi = 0, bad_lo = 0, sdo_moves = 0, clk_outside = 0, busy_gap = 0;
    logic p_sclk = 1'b0, p_cs = 1'b1, p_sdo = 1'b0;
    exp_v = expect_stream(c);
    @(negedge clk);
    codes = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_c < 0 && cyc < 5000) begin
      cyc++;
      if (cyc == poke_at) begin
        start = 1'b1;
        codes = ~c;
      end else if (cyc == poke_at + 1) begin
        start = 1'b0;
      end
      if (!cs_ld && p_cs) begin cs_falls++; cs_fall_c = cyc; end
      if (cs_ld && !p_cs) cs_rise_c = cyc;
      if (sclk && cs_ld) clk_outside++;
      if (sclk && !p_sclk) begin
        rises++;
        if (first_rise_c < 0) first_rise_c = cyc;
        else if (cyc - fall_c != T_L) bad_lo++;
        rise_c = cyc;
        got = {got[TOT-2:0], sdo};
        if (sdo !== p_sdo) sdo_moves++;
      end else if (sclk && sdo !== p_sdo) sdo_moves++;
      if (!sclk && p_sclk) begin
        fall_c = cyc;
        if (cyc - rise_c != T_H) bad_hi++;
      end
      if (!busy) busy_gap++;
      if (done) done_c = cyc;
      p_sclk = sclk; p_cs = cs_ld; p_sdo = sdo;
      @(negedge clk);
    end
    if (done_c < 0) chk(1'b0, "R7", "watchdog, no done", cyc, LAT);
    chk(got === exp_v, "R2", "bit stream", longint'(got), longint'(exp_v));
    chk(rises == TOT, "R2", "rising edge count", rises, TOT);
    chk(first_rise_c - cs_fall_c == T_S, "R3", "select to first clock", first_rise_c - cs_fall_c, T_S);
    chk(bad_hi == 0, "R4", "high phases of wrong width", bad_hi, 0);
    chk(bad_lo == 0, "R4", "low phases of wrong width", bad_lo, 0);
    chk(sdo_moves == 0, "R5", "data moves while clock high", sdo_moves, 0);
    chk(cs_rise_c - fall_c == T_P, "R6", "last fall to load", cs_rise_c - fall_c, T_P);
    chk(done_c - cs_rise_c == T_LD, "R7", "load pulse width", done_c - cs_rise_c, T_LD);
    chk(done_c == LAT, "R7", "start to done latency", done_c, LAT);
    chk(busy_gap == 0, "R7", "busy low during transfer", busy_gap, 0);
    chk(cs_falls == 1 && clk_outside == 0, "R9", "select windows", cs_falls, 1);
    @(negedge clk);
    chk(!done, "R7", "done width", done, 0);
    for (int i = 0; i < 3*(T_S + T_H + T_L); i++) begin
      if (!cs_ld || sclk || done || busy) begin
        chk(1'b0, (poke_at > 0) ? "R8" : "R1", "activity after done", {cs_ld, sclk, done, busy}, 4'b1000);
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N_DEV*CW-1:0] rc;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(cs_ld === 1'b1 && sclk === 1'b0, "R1", "select/clock in reset", {cs_ld, sclk}, 2'b10);
    chk(done === 1'b0 && busy === 1'b0, "R1", "done/busy in reset", {done, busy}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_ld === 1'b1 && sclk === 1'b0 && !busy, "R1", "idle after reset", {cs_ld, sclk, busy}, 3'b100);
    run_xfer('0, 0);
    run_xfer('1, 0);
    run_xfer({N_DEV{14'h2AAA}}, 0);
    run_xfer({14'h2001, 14'h0000, 14'h3FFF}, 0);
    run_xfer({14'h1234, 14'h0ABC, 14'h3C3C}, 40);   // R8: start and code change mid-transfer
    run_xfer({14'h0F0F, 14'h3333, 14'h1111}, LAT - 3);
    for (int t = 0; t < 12; t++) begin
      for (int d = 0; d < N_DEV; d++) rc[d*CW +: CW] = CW'($urandom);
      run_xfer(rc, (t % 3 == 0) ? int'($urandom_range(2, LAT - 2)) : 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule